// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer and Refresh Timer

This block takes a single-rank SDR SDRAM device from reset to normal operation. It starts by enabling the clock to the device. It then waits out the power-up settling time and applies the required sequence on the command pins: one precharge of all banks, a burst of auto-refresh commands, and one mode-register load. After the last of these commands it reports that initialization is complete. Every timing gap comes from parameters. Gaps given in nanoseconds become clock counts through the truncating conversion (clock MHz × ns) / 1000.

Once initialization is complete, the block counts refresh intervals. Each interval is the clock count for one row's share of the 64 ms retention window, minus a fixed margin. When an interval ends, the block raises a refresh request toward the access arbiter. It puts an auto-refresh on the command pins only in a cycle where the arbiter grants the bus. A new interval starts at every issued refresh. If a request is still waiting when the next interval ends, a sticky overrun flag is set. Data paths, user row and bank handling, and arbitration belong to other blocks.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, cke, init_done, ref_req, ref_ack and ref_overrun are all low. The command pins carry NOP, coded (cs_n,ras_n,cas_n,we_n) = 0111, and addr and ba are zero.
- R2: The reset is released through a two-stage synchronizer. cke rises on the third rising edge after reset is released and then stays high. The command pins carry NOP until PRECHARGE ALL, which appears exactly 200 µs of clock cycles after cke rises (10000 cycles at 50 MHz).
- R3: PRECHARGE ALL is coded 0010, with addr bit 10 set, all other addr bits zero, and ba zero. The next command follows max(tRP,1)+1 cycles later, where tRP is 18 ns converted with truncation (0 clocks at 50 MHz, so the gap is 2 cycles).
- R4: Exactly eight AUTO REFRESH commands (0001) follow the precharge. Two successive ones are max(tRFC,1)+1 cycles apart, where tRFC is 60 ns in clocks (3 at 50 MHz, so the gap is 4 cycles).
- R5: LOAD MODE REGISTER (0000) follows the last initial refresh after the same tRFC gap. It carries addr = 0x030 (burst code 0 in bits [2:0], CAS latency 3 in bits [6:4], all other bits 0) and ba zero.
- R6: init_done rises max(tMRD,1)+1 = 2 cycles after the mode-register load and stays high. No command other than the ten listed ones appears before init_done.
- R7: The refresh interval is N = ns_to_clk(64 ms / 8192 rows, truncated to 7812 ns) − 20, which is 370 at 50 MHz. ref_req first rises N+1 cycles after init_done rises.
- R8: In the first cycle where grant is sampled high while ref_req is high, AUTO REFRESH (0001) and a one-cycle ref_ack appear on the next clock edge, and ref_req falls on that same edge.
- R9: A new interval starts at each issued refresh: ref_req rises again N+1 cycles after the ref_ack cycle, even when the grant came late.
- R10: While grant stays low, ref_req stays high, no AUTO REFRESH is issued and ref_ack stays low. A second expiry, N+1 cycles after ref_req rose, sets ref_overrun, which stays high through later refreshes until reset.
- R11: grant has no effect before init_done: the initialization command sequence and its timing are unchanged when grant is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Arbiter permits a refresh command this cycle |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 12 | Address for precharge-all and mode-register commands |
| ba | output | 2 | Bank address, always zero |
| init_done | output | 1 | Initialization complete |
| ref_req | output | 1 | A refresh is pending |
| ref_ack | output | 1 | One-cycle pulse that marks an issued refresh |
| ref_overrun | output | 1 | Sticky flag: a refresh interval expired while one was pending |

## Verification
The initialization run holds grant high from the start, so a wrongly gated grant would show up as an extra command among the ten expected ones. In normal mode, grant is held high for two intervals, which shows that the period equals the interval plus the request and issue cycles. Grant is then held low across a full interval, which tells deferral apart from dropping the request and shows the overrun setting on the exact cycle. A late grant that follows shows whether the next interval is measured from the issue or from the expiry.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_PRE,
    ST_PRE_WAIT,
    ST_REF,
    ST_REF_WAIT,
    ST_LMR,
    ST_LMR_WAIT,
    ST_DONE
  } init_st_e;

  // truncating nanosecond to clock conversion
  function automatic int ns_to_clk(input int mhz, input int ns);
    return (mhz * ns) / 1000;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int PWRUP_CYC = 10000,
  parameter int RP_CYC    = 1,
  parameter int RFC_CYC   = 3,
  parameter int MRD_CYC   = 1,
  parameter int NREF      = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  output sd_cmd_e cmd_o,
  output logic    done_o
);
  localparam int MAXW   = imax(imax(PWRUP_CYC, RP_CYC), imax(RFC_CYC, MRD_CYC));
  localparam int WAIT_W = $clog2(MAXW + 1);
  localparam int CNT_W  = (NREF > 1) ? $clog2(NREF) : 1;

  init_st_e          state_q, state_n;
  logic [WAIT_W-1:0] wait_q, wait_n;
  logic [CNT_W-1:0]  ref_cnt_q, ref_cnt_n;
  logic              run_en;
  logic              wait_end;

  assign run_en   = (state_q != ST_DONE);
  assign wait_end = (wait_q <= WAIT_W'(1));

  always_comb begin
    state_n   = state_q;
    wait_n    = wait_q;
    ref_cnt_n = ref_cnt_q;
    cmd_o     = CMD_NOP;
    unique case (state_q)
      ST_PWRUP: begin
        if (wait_end) state_n = ST_PRE;
        else          wait_n  = wait_q - WAIT_W'(1);
      end
      ST_PRE: begin
        cmd_o   = CMD_PRE;
        wait_n  = WAIT_W'(RP_CYC);
        state_n = ST_PRE_WAIT;
      end
      ST_PRE_WAIT: begin
        if (wait_end) state_n = ST_REF;
        else          wait_n  = wait_q - WAIT_W'(1);
      end
      ST_REF: begin
        cmd_o   = CMD_AREF;
        wait_n  = WAIT_W'(RFC_CYC);
        state_n = ST_REF_WAIT;
      end
      ST_REF_WAIT: begin
        if (wait_end) begin
          if (ref_cnt_q == CNT_W'(NREF - 1)) begin
            state_n   = ST_LMR;
            ref_cnt_n = '0;
          end else begin
            state_n   = ST_REF;
            ref_cnt_n = ref_cnt_q + CNT_W'(1);
          end
        end else begin
          wait_n = wait_q - WAIT_W'(1);
        end
      end
      ST_LMR: begin
        cmd_o   = CMD_LMR;
        wait_n  = WAIT_W'(MRD_CYC);
        state_n = ST_LMR_WAIT;
      end
      ST_LMR_WAIT: begin
        if (wait_end) state_n = ST_DONE;
        else          wait_n  = wait_q - WAIT_W'(1);
      end
      default: state_n = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_PWRUP;
      wait_q    <= WAIT_W'(PWRUP_CYC);
      ref_cnt_q <= '0;
    end else if (run_en) begin
      state_q   <= state_n;
      wait_q    <= wait_n;
      ref_cnt_q <= ref_cnt_n;
    end
  end

  assign done_o = (state_q == ST_DONE);

  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REF_WAIT) |-> (wait_q <= WAIT_W'(RFC_CYC))); // R4

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REF_CYC = 370
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic grant_i,
  output logic issue_o,
  output logic req_o,
  output logic overrun_o
);
  localparam int CW = $clog2(REF_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          pend_q, pend_n;
  logic          ovr_q, ovr_n;
  logic          expire;

  assign expire  = run_i && (cnt_q == '0);
  assign issue_o = run_i && pend_q && grant_i;

  always_comb begin
    cnt_n  = cnt_q;
    pend_n = pend_q;
    ovr_n  = ovr_q;
    if (!run_i) begin
      cnt_n = CW'(REF_CYC);
    end else if (issue_o) begin
      cnt_n  = CW'(REF_CYC);
      pend_n = 1'b0;
    end else if (expire) begin
      cnt_n  = CW'(REF_CYC);
      pend_n = 1'b1;
      ovr_n  = ovr_q | pend_q;
    end else begin
      cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(REF_CYC);
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      ovr_q  <= ovr_n;
    end
  end

  assign req_o     = pend_q;
  assign overrun_o = ovr_q;

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q); // R10
  AST_NO_REQ_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !pend_q); // R7
  AST_HELD_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !grant_i) |=> pend_q); // R10

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ      = 50,
  parameter int PWRUP_US     = 200,
  parameter int T_RP_NS      = 18,
  parameter int T_RFC_NS     = 60,
  parameter int T_MRD_CLK    = 1,
  parameter int INIT_REFS    = 8,
  parameter int RETAIN_MS    = 64,
  parameter int ROW_COUNT    = 8192,
  parameter int REF_MARGIN   = 20,
  parameter int CAS_LAT      = 3,
  parameter int BURST_CODE   = 0,
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done,
  output logic              ref_req,
  output logic              ref_ack,
  output logic              ref_overrun
);
  localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
  localparam int RP_CYC    = imax(ns_to_clk(CLK_MHZ, T_RP_NS), 1);
  localparam int RFC_CYC   = imax(ns_to_clk(CLK_MHZ, T_RFC_NS), 1);
  localparam int MRD_CYC   = imax(T_MRD_CLK, 1);
  localparam int ROW_NS    = (RETAIN_MS * 1000000) / ROW_COUNT;
  localparam int REF_CYC   = ns_to_clk(CLK_MHZ, ROW_NS) - REF_MARGIN;
  localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1 << 10);
  localparam logic [ADDR_W-1:0] MODE_WORD    =
    ADDR_W'(((CAS_LAT & 7) << 4) | (BURST_CODE & 7));

  logic    rst_sn;
  sd_cmd_e fsm_cmd;
  logic    fsm_done;
  logic    issue;
  sd_cmd_e cmd_n, cmd_q;
  logic [ADDR_W-1:0] addr_n, addr_q;
  logic    cke_q, done_q, ack_q;

  sdram_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_sn)
  );

  sdram_init_fsm #(
    .PWRUP_CYC(PWRUP_CYC), .RP_CYC(RP_CYC), .RFC_CYC(RFC_CYC),
    .MRD_CYC(MRD_CYC), .NREF(INIT_REFS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sn), .cmd_o(fsm_cmd), .done_o(fsm_done)
  );

  sdram_refresh_timer #(.REF_CYC(REF_CYC)) u_ref (
    .clk(clk), .rst_n(rst_sn), .run_i(done_q), .grant_i(grant),
    .issue_o(issue), .req_o(ref_req), .overrun_o(ref_overrun)
  );

  always_comb begin
    if (!done_q) cmd_n = fsm_cmd;
    else         cmd_n = issue ? CMD_AREF : CMD_NOP;
    unique case (cmd_n)
      CMD_PRE: addr_n = PRE_ALL_ADDR;
      CMD_LMR: addr_n = MODE_WORD;
      default: addr_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cke_q  <= 1'b0;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      done_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      cke_q  <= 1'b1;
      cmd_q  <= cmd_n;
      addr_q <= addr_n;
      done_q <= fsm_done;
      ack_q  <= done_q && issue;
    end
  end

  assign cke       = cke_q;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr      = addr_q;
  assign ba        = '0;
  assign init_done = done_q;
  assign ref_ack   = ack_q;

  // assertion-only count of refreshes seen before init_done
  logic [7:0] aref_seen_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)                             aref_seen_q <= '0;
    else if (!done_q && cmd_q == CMD_AREF)   aref_seen_q <= aref_seen_q + 8'd1;
  end

  AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_sn)
    cke_q |=> cke_q); // R2
  AST_INIT_AREF_COUNT: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_q == CMD_LMR) |-> (aref_seen_q == 8'(INIT_REFS))); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |=> done_q); // R6
  AST_ACK_WITH_AREF: assert property (@(posedge clk) disable iff (!rst_sn)
    ack_q |-> (cmd_q == CMD_AREF)); // R8
  AST_ACK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_sn)
    ack_q |-> ($past(grant) && $past(ref_req))); // R8

endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int MHZ   = 50;
  localparam int SYNC  = 2;

  function automatic int n2c(input int ns);
    return (MHZ * ns) / 1000;
  endfunction
  function automatic int gap(input int c);
    return ((c > 1) ? c : 1) + 1;
  endfunction

  localparam int CKE_C = SYNC + 1;
  localparam int PRE_C = CKE_C + MHZ * 200;
  localparam int G_RP  = gap(n2c(18));
  localparam int G_RFC = gap(n2c(60));
  localparam int G_MRD = gap(1);
  localparam int REF_N = n2c(64000000 / 8192) - 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, ref_req, ref_ack, ref_overrun;
  logic [11:0] addr;
  logic [1:0]  ba;
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int done_cyc = 0;
  int ack_cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  sdram_init_seq uut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done), .ref_req(ref_req),
    .ref_ack(ref_ack), .ref_overrun(ref_overrun)
  );

  function automatic logic [3:0] cmd();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic to_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(cke == 0, "R1", "cke in reset", cke, 0);
    chk(cmd() == 4'b0111, "R1", "cmd in reset", cmd(), 4'b0111);
    chk(init_done == 0 && ref_req == 0, "R1", "flags in reset",
        {init_done, ref_req}, 0);
    chk(ref_ack == 0 && ref_overrun == 0, "R1", "ack/overrun in reset",
        {ref_ack, ref_overrun}, 0);
    chk(addr == 0 && ba == 0, "R1", "addr in reset", addr, 0);
  endtask

  task automatic t_init();
    int ev_c [16];
    logic [3:0] ev_k [16];
    logic [11:0] ev_a [16];
    int nev = 0;
    int cke_bad = 0;
    int cke_rise = 0;
    grant = 1'b1; // R11: held high through init
    rst_n = 1'b1;
    @(negedge clk);
    while (!init_done && cyc < 20000) begin
      if (cke && cke_rise == 0) cke_rise = cyc;
      if (!cke && cke_rise != 0) cke_bad++;
      if (cmd() != 4'b0111) begin
        if (nev < 16) begin
          ev_c[nev] = cyc; ev_k[nev] = cmd(); ev_a[nev] = addr;
        end
        nev++;
      end
      @(negedge clk);
    end
    done_cyc = cyc;
    chk(cke_rise == CKE_C, "R2", "cke rise cycle", cke_rise, CKE_C);
    chk(cke_bad == 0, "R2", "cke dropped", cke_bad, 0);
    chk(nev == 10, "R11", "init command count", nev, 10);
    if (nev == 10) begin
      chk(ev_c[0] == PRE_C, "R2", "precharge cycle", ev_c[0], PRE_C);
      chk(ev_k[0] == 4'b0010, "R3", "precharge code", ev_k[0], 4'b0010);
      chk(ev_a[0] == 12'h400, "R3", "precharge addr", ev_a[0], 12'h400);
      for (int k = 0; k < 8; k++) begin
        chk(ev_k[k+1] == 4'b0001, "R4", "refresh code", ev_k[k+1], 4'b0001);
        chk(ev_c[k+1] == PRE_C + G_RP + k * G_RFC, "R4", "refresh cycle",
            ev_c[k+1], PRE_C + G_RP + k * G_RFC);
      end
      chk(ev_c[1] - ev_c[0] == G_RP, "R3", "tRP gap", ev_c[1] - ev_c[0], G_RP);
      chk(ev_k[9] == 4'b0000, "R5", "mode load code", ev_k[9], 4'b0000);
      chk(ev_a[9] == 12'h030, "R5", "mode word", ev_a[9], 12'h030);
      chk(ev_c[9] == ev_c[8] + G_RFC, "R5", "mode load cycle", ev_c[9], ev_c[8] + G_RFC);
      chk(done_cyc == ev_c[9] + G_MRD, "R6", "init_done cycle", done_cyc, ev_c[9] + G_MRD);
    end
    chk(ba == 0, "R5", "bank addr", ba, 0);
  endtask

  task automatic t_refresh_served();
    int r1 = done_cyc + REF_N + 1;
    grant = 1'b1;
    to_cyc(r1 - 1);
    chk(ref_req == 0, "R7", "req before interval", ref_req, 0);
    to_cyc(r1);
    chk(ref_req == 1, "R7", "req at interval", ref_req, 1);
    to_cyc(r1 + 1);
    chk(cmd() == 4'b0001 && ref_ack == 1, "R8", "refresh issued",
        {cmd(), ref_ack}, 5'b00011);
    chk(ref_req == 0, "R8", "req cleared", ref_req, 0);
    ack_cyc = r1 + 1;
    to_cyc(ack_cyc + 1);
    chk(ref_ack == 0 && cmd() == 4'b0111, "R8", "ack one cycle",
        {cmd(), ref_ack}, 5'b01110);
    to_cyc(ack_cyc + REF_N);
    chk(ref_req == 0, "R9", "second req early", ref_req, 0);
    to_cyc(ack_cyc + REF_N + 1);
    chk(ref_req == 1, "R9", "second req", ref_req, 1);
    to_cyc(ack_cyc + REF_N + 2);
    chk(ref_ack == 1, "R9", "second issue", ref_ack, 1);
    ack_cyc = ack_cyc + REF_N + 2;
    grant = 1'b0;
  endtask

  task automatic t_late_grant();
    int rq = ack_cyc + REF_N + 1;
    int bad = 0;
    to_cyc(rq);
    chk(ref_req == 1, "R10", "req pending", ref_req, 1);
    while (cyc < rq + REF_N) begin
      @(negedge clk);
      if (!ref_req || ref_ack || cmd() != 4'b0111) bad++;
    end
    chk(bad == 0, "R10", "no refresh without grant", bad, 0);
    chk(ref_overrun == 0, "R10", "overrun early", ref_overrun, 0);
    to_cyc(rq + REF_N + 1);
    chk(ref_overrun == 1, "R10", "overrun set", ref_overrun, 1);
    to_cyc(rq + REF_N + 7);
    grant = 1'b1;
    to_cyc(rq + REF_N + 8);
    chk(ref_ack == 1 && cmd() == 4'b0001, "R8", "late grant issue",
        {cmd(), ref_ack}, 5'b00011);
    ack_cyc = rq + REF_N + 8;
    grant = 1'b0;
    to_cyc(ack_cyc + REF_N);
    chk(ref_req == 0, "R9", "interval from issue, early", ref_req, 0);
    to_cyc(ack_cyc + REF_N + 1);
    chk(ref_req == 1, "R9", "interval from issue", ref_req, 1);
    chk(ref_overrun == 1, "R10", "overrun sticky", ref_overrun, 1);
  endtask

  initial begin
    t_reset();
    t_init();
    t_refresh_served();
    t_late_grant();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule